// File: doc/BRIEF.md
# One-Time-Programmable Array Mode Decoder

This block is the device-side control for a one-time-programmable byte array. Three active-low strobes decide what the block does: a select strobe (`selN`), a read strobe (`readEnN`) and a burn strobe (`burnN`). Together they pick read/verify, output off, standby, page load, page burn or byte burn. The read path drives the addressed cell onto the output data bus with an explicit output enable, which stands in for a bidirectional pad. Programming works in one of two ways. Up to four bytes can be collected in a page buffer and then burned in one go, or a single byte can be burned at its full address.

A burn happens on the trailing (rising) edge of a low pulse on `burnN`. It only takes effect when the pulse was long enough and the digital program-voltage-present input `vppOk` is high. The array cells leave reset erased to all ones. A burn can only clear bits, because the stored byte is ANDed with the burned byte. The strobes are assumed to be synchronous to `clk`.

Top module: `otp_prog_ctrl`

## Requirements
- R1: With `selN`=0 and `readEnN`=0, `dataOutEn` is 1 and `dataOut` equals the cell at `addrIn` in the same cycle.
- R2: `dataOutEn` is 0 whenever `readEnN`=1 or `selN`=1.
- R3: `modeCode` decodes {selN,readEnN,burnN} as follows:
  - 00x gives 0 (read/verify).
  - 011 gives 1 (output off).
  - 1x1 with readEnN=1, that is 111, gives 2 (standby), and 100 also gives 2.
  - 101 gives 3 (page load).
  - 110 gives 4 (page burn).
  - 010 gives 5 (byte burn).
- R4: In page load mode, each clock edge stores `dataIn` into the buffer slot chosen by `addrIn[1:0]`, and stores `addrIn[ADDR_W-1:2]` as the page address.
- R5: A `burnN` rising edge with `selN`=1, `readEnN`=1 and `vppOk`=1, after at least MIN_PULSE low cycles, ANDs all four buffer slots into the four cells of the stored page.
- R6: The same edge with `selN`=0 ANDs `dataIn` into the single cell at `addrIn`.
- R7: Cells reset to 8'hFF, and a burn can never set a cell bit from 0 to 1.
- R8: A burn pulse shorter than MIN_PULSE cycles changes no cell and sets `shortPulse`. `shortPulse` stays set until reset.
- R9: While `vppOk`=0, no burn changes a cell and `shortPulse` is not set.
- R10: A rising edge of `vppOk` refills all four page buffer slots with 8'hFF.
- R11: While `burnN` stays high, no cell changes, whatever the other strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selN | input | 1 | Active-low device select strobe |
| readEnN | input | 1 | Active-low read strobe |
| burnN | input | 1 | Active-low programming pulse |
| vppOk | input | 1 | Program voltage present |
| addrIn | input | ADDR_W | Byte address; bits [1:0] pick the page slot |
| dataIn | input | 8 | Data bus as seen by the block |
| dataOut | output | 8 | Read data |
| dataOutEn | output | 1 | Drive enable for the data bus |
| modeCode | output | 3 | Decoded operating mode |
| shortPulse | output | 1 | Sticky flag for a rejected short burn pulse |

## Verification
The bench aims at the pulse-length boundary. A pulse exactly MIN_PULSE cycles long must burn, and one a cycle shorter must not. A design with an off-by-one counter would either burn the second byte or reject the first. It burns a byte twice to catch a design that overwrites the cell instead of ANDing into it, because such a design would bring cleared bits back. It checks that the page buffer is refilled when the program voltage comes back, so that stale slots from an earlier page are not burned. It also checks that burns are dropped while `vppOk` is low, since a missing gate would change cells with no program voltage present.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [2:0] {
    MODE_READ       = 3'd0,
    MODE_OUT_OFF    = 3'd1,
    MODE_STANDBY    = 3'd2,
    MODE_PAGE_LOAD  = 3'd3,
    MODE_PAGE_BURN  = 3'd4,
    MODE_BYTE_BURN  = 3'd5
  } otpModeT;

  typedef struct packed {
    logic latchEn;
    logic latchClr;
    logic pageWr;
    logic byteWr;
    logic driveOut;
  } otpStrobeT;

endpackage

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
  import otp_prog_pkg::*;
#(
  parameter int MIN_PULSE = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selN,
  input  logic      readEnN,
  input  logic      burnN,
  input  logic      vppOk,
  output otpStrobeT strb,
  output otpModeT   modeCode,
  output logic      shortPulse
);

  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

  logic [CNT_W-1:0] lowCnt;
  logic             vppPrev;
  logic             burnRise;
  logic             longEnough;
  logic             shortHit;

  // mode decode from the three strobes
  always_comb begin
    unique case ({selN, readEnN, burnN})
      3'b000, 3'b001: modeCode = MODE_READ;
      3'b010:         modeCode = MODE_BYTE_BURN;
      3'b011:         modeCode = MODE_OUT_OFF;
      3'b101:         modeCode = MODE_PAGE_LOAD;
      3'b110:         modeCode = MODE_PAGE_BURN;
      default:        modeCode = MODE_STANDBY;
    endcase
  end

  // saturating count of low cycles on the burn strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (burnN) begin
      lowCnt <= '0;
    end else if (lowCnt != CNT_MAX) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vppPrev <= 1'b0;
    else       vppPrev <= vppOk;
  end

  assign burnRise   = burnN && (lowCnt != '0);
  assign longEnough = (lowCnt >= CNT_MAX);
  assign shortHit   = burnRise && readEnN && vppOk && !longEnough;

  always_comb begin
    strb.latchEn  = selN && !readEnN && burnN;
    strb.latchClr = vppOk && !vppPrev;
    strb.pageWr   = burnRise && readEnN && selN && vppOk && longEnough;
    strb.byteWr   = burnRise && readEnN && !selN && vppOk && longEnough;
    strb.driveOut = !selN && !readEnN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         shortPulse <= 1'b0;
    else if (shortHit) shortPulse <= 1'b1;
  end

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    shortPulse |=> shortPulse);

  a_r9_no_burn_without_vpp: assert property (@(posedge clk) disable iff (!rstN)
    !vppOk |-> !(strb.pageWr || strb.byteWr));

  a_r11_held_high_no_burn: assert property (@(posedge clk) disable iff (!rstN)
    (burnN && $past(burnN)) |-> !(strb.pageWr || strb.byteWr));

  a_r3_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchEn, strb.pageWr, strb.byteWr}));

endmodule

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  otpStrobeT         strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int CELLS  = 1 << ADDR_W;
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic [DATA_W-1:0] cells   [CELLS];
  logic [DATA_W-1:0] pageBuf [PAGE_BYTES];
  logic [PAGE_W-1:0] pageAddr;
  logic [SLOT_W-1:0] slotSel;

  assign slotSel = addrIn[SLOT_W-1:0];

  // page buffer: cleared on program-voltage entry, loaded per slot
  generate
    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pageBuf[s] <= '1;
        end else if (strb.latchClr) begin
          pageBuf[s] <= '1;
        end else if (strb.latchEn && slotSel == SLOT_W'(s)) begin
          pageBuf[s] <= dataIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pageAddr <= '0;
    else if (strb.latchEn) pageAddr <= addrIn[ADDR_W-1:SLOT_W];
  end

  // one-time array: bits can only go from 1 to 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CELLS; i++) cells[i] <= '1;
    end else if (strb.byteWr) begin
      cells[addrIn] <= cells[addrIn] & dataIn;
    end else if (strb.pageWr) begin
      for (int s = 0; s < PAGE_BYTES; s++) begin
        cells[{pageAddr, SLOT_W'(s)}] <= cells[{pageAddr, SLOT_W'(s)}] & pageBuf[s];
      end
    end
  end

  assign dataOut   = cells[addrIn];
  assign dataOutEn = strb.driveOut;

  a_r7_byte_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteWr |=> ((cells[$past(addrIn)] & ~$past(cells[addrIn])) == '0));

  a_r10_buffer_refill: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchClr |=> (pageBuf[0] == '1 && pageBuf[PAGE_BYTES-1] == '1));

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              readEnN,
  input  logic              burnN,
  input  logic              vppOk,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn,
  output logic [2:0]        modeCode,
  output logic              shortPulse
);

  otpStrobeT strb;
  otpModeT   modeInt;

  otp_mode_ctrl #(.MIN_PULSE(MIN_PULSE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .selN      (selN),
    .readEnN   (readEnN),
    .burnN     (burnN),
    .vppOk     (vppOk),
    .strb      (strb),
    .modeCode  (modeInt),
    .shortPulse(shortPulse)
  );

  otp_datapath #(.ADDR_W(ADDR_W), .DATA_W(8), .PAGE_BYTES(4)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addrIn   (addrIn),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataOutEn(dataOutEn)
  );

  assign modeCode = modeInt;

  a_r2_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    (readEnN || selN) |-> !dataOutEn);

endmodule

// File: tb/otp_prog_ctrl_tb.sv
module otp_prog_ctrl_tb;

  localparam int ADDR_W = 9;
  localparam int MINP   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, readEnN = 1'b1, burnN = 1'b1, vppOk = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOutEn, shortPulse;
  logic [2:0] modeCode;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  otp_prog_ctrl #(.ADDR_W(ADDR_W), .MIN_PULSE(MINP)) u_dut (.*);

  // {selN, readEnN, burnN, expected mode, expected drive}
  localparam logic [6:0] VEC [8] = '{
    7'b000_000_1, 7'b001_000_1, 7'b010_101_0, 7'b011_001_0,
    7'b100_010_0, 7'b101_011_0, 7'b110_100_0, 7'b111_010_0 };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, input string req, input int exp);
    @(negedge clk);
    selN = 0; readEnN = 0; burnN = 1; addrIn = ADDR_W'(a);
    #2;
    chk(req, dataOut, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); burnN = 0;
    repeat (n) @(negedge clk);
    burnN = 1;
    @(negedge clk);
  endtask

  task automatic byteBurn(input int a, input int d, input int n);
    @(negedge clk);
    selN = 0; readEnN = 1; burnN = 1; addrIn = ADDR_W'(a); dataIn = 8'(d);
    pulse(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    // reset state R7 / R2
    chk("R2 reset drive", dataOutEn, 0);
    chk("R8 reset flag", shortPulse, 0);
    rd(5, "R7 erased", 8'hFF);

    // decode table R3, R1, R2
    foreach (VEC[i]) begin
      @(negedge clk);
      {selN, readEnN, burnN} = VEC[i][6:4];
      #2;
      chk("R3 mode", modeCode, VEC[i][3:1]);
      chk("R2 drive", dataOutEn, VEC[i][0]);
    end
    @(negedge clk); burnN = 1;

    // byte burn R6, then AND semantics R7
    @(negedge clk); vppOk = 1;
    byteBurn(9'h10, 8'hA5, MINP);
    rd(9'h10, "R6 byte burn", 8'hA5);
    chk("R1 drive", dataOutEn, 1);
    byteBurn(9'h10, 8'hF0, MINP);
    rd(9'h10, "R7 only clears", 8'hA0);

    // short pulse R8
    byteBurn(9'h20, 8'h00, MINP - 1);
    rd(9'h20, "R8 short ignored", 8'hFF);
    chk("R8 flag", shortPulse, 1);

    // no program voltage R9
    @(negedge clk); vppOk = 0;
    byteBurn(9'h30, 8'h00, MINP + 2);
    rd(9'h30, "R9 no vpp", 8'hFF);

    // page load and burn R4 R5 (vppOk rises first)
    @(negedge clk); vppOk = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      selN = 1; readEnN = 0; burnN = 1; addrIn = ADDR_W'(9'h44 + k); dataIn = 8'(8'h10 + k);
    end
    @(negedge clk); readEnN = 1; addrIn = '0;
    pulse(MINP);
    for (int k = 0; k < 4; k++) rd(9'h44 + k, "R5 page burn", 8'h10 + k);

    // buffer refill on vpp rise R10
    @(negedge clk); vppOk = 0;
    @(negedge clk); vppOk = 1;
    @(negedge clk);
    selN = 1; readEnN = 0; burnN = 1; addrIn = 9'h82; dataIn = 8'h3C;
    @(negedge clk); readEnN = 1;
    pulse(MINP);
    rd(9'h80, "R10 slot0 refilled", 8'hFF);
    rd(9'h81, "R10 slot1 refilled", 8'hFF);
    rd(9'h82, "R4 slot2", 8'h3C);
    rd(9'h83, "R10 slot3 refilled", 8'hFF);

    // burn held high R11
    @(negedge clk); selN = 1; readEnN = 1; burnN = 1;
    repeat (6) @(negedge clk);
    @(negedge clk); selN = 0; readEnN = 1; addrIn = 9'h10; dataIn = 8'h00;
    repeat (6) @(negedge clk);
    rd(9'h10, "R11 held high", 8'hA0);
    rd(9'h82, "R11 held high page", 8'h3C);
    chk("R8 sticky", shortPulse, 1);

    @(negedge clk); selN = 1; #2;
    chk("R2 released", dataOutEn, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule